// File: doc/BRIEF.md
# Sync-Header Error-Rate Monitor

This block watches the two-bit sync header of every 64b/66b block that a 10GBASE-R receiver delivers once block alignment is held. Each block arrives as a one-cycle strobe with a flag that says whether its header was legal. The block counts illegal headers inside a fixed measurement window of 125 us. When 16 of them land in one window, it raises a high-error-ratio flag. That count corresponds to a bit error ratio worse than 1e-4.

The window comes from a free-running timer. Its terminal count is derived from the clock frequency parameter (`CLK_KHZ`). Once raised, the flag is held for at least one full window after the most recent trigger. It drops only at a window boundary where the hold has run out and the window just closed stayed under the limit. While block lock is absent, the monitor parks: the flag is forced high, and the timer and window count sit at zero.

A separate statistics counter records every entry into the bad-header condition. It saturates at its maximum value. A dedicated clear input zeroes it without touching the monitor.

Top module: `ber_mon`

## Requirements
- R1: The measurement window is exactly WIN = CLK_KHZ*125/1000 clock cycles long. Its first cycle follows reset release or lock acquisition, and it restarts immediately at every boundary, so the last cycle of a window still counts toward that window.
- R2: An invalid header is a cycle with `hdr_vld`=1, `hdr_ok`=0 and `lock`=1. When the LIMIT-th (16th) invalid header of one window arrives, `hi_ber` is 1 from the next cycle on. LIMIT-1 invalid headers in one window leave it at 0.
- R3: The window count starts from zero at every window boundary. Invalid headers split across two adjacent windows are never added together.
- R4: After a trigger, `hi_ber` stays 1 for at least WIN cycles. It returns to 0 at the first window boundary at which WIN cycles have passed since the latest trigger and the closing window held fewer than LIMIT invalid headers.
- R5: `bad_stat` increases by one in the cycle after each invalid header.
- R6: `bad_stat` stops at 2^STAT_W-1 and does not wrap.
- R7: `stat_clr`=1 makes `bad_stat` 0 in the next cycle, even when an invalid header arrives in the same cycle. It has no effect on `hi_ber`, the timer or the window count.
- R8: While `lock`=0, `hi_ber` is 1 from the next cycle, headers are ignored, and the timer, window count and hold time restart. After lock returns, `hi_ber` stays 1 for at least WIN cycles.
- R9: Synchronous reset `rst`=1 sets `hi_ber` and `bad_stat` to 0 and clears the timer and the window count.
- R10: A cycle with `hdr_vld`=0 is ignored, whatever `hdr_ok` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| lock | input | 1 | Block lock is currently held |
| hdr_vld | input | 1 | A received block is present this cycle |
| hdr_ok | input | 1 | The present block has a legal sync header |
| stat_clr | input | 1 | Zero the statistics counter |
| hi_ber | output | 1 | High bit-error-ratio flag |
| bad_stat | output | STAT_W | Saturating count of invalid headers seen under lock |

## Verification
The hardest situations to reach are the ones that depend on where the timer sits inside the window. These are a burst straddling a boundary, a 16th error landing in the last cycle of a window, and the exact cycle at which the hold expires. The window phase cannot be read at the ports. The stimulus therefore keeps a phase counter that starts from the known reset and relock points, and places bursts relative to that phase. A random phase mixing error densities, lock drops and clears then compares both outputs each cycle against a model derived from the requirements.

// File: rtl/ber_mon.sv
module ber_mon #(
  parameter int CLK_KHZ = 161133,
  parameter int LIMIT   = 16,
  parameter int STAT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock,
  input  logic              hdr_vld,
  input  logic              hdr_ok,
  input  logic              stat_clr,
  output logic              hi_ber,
  output logic [STAT_W-1:0] bad_stat
);
  localparam int WIN = CLK_KHZ * 125 / 1000;
  localparam int TW  = $clog2(WIN + 1);
  localparam int CW  = $clog2(LIMIT + 1);

  logic [TW-1:0] tmr, hold;
  logic [CW-1:0] wcnt;

  wire          bad       = lock & hdr_vld & ~hdr_ok;
  wire          tick      = (tmr == TW'(WIN - 1));
  wire [CW:0]   nxt       = {1'b0, wcnt} + (CW+1)'(bad);
  wire          trig      = bad & (nxt >= (CW+1)'(LIMIT));
  wire          hold_done = (hold == TW'(WIN));
  wire          stat_max  = &bad_stat;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr    <= '0;
      wcnt   <= '0;
      hold   <= '0;
      hi_ber <= 1'b0;
    end else if (!lock) begin
      tmr    <= '0;
      wcnt   <= '0;
      hold   <= '0;
      hi_ber <= 1'b1;
    end else begin
      tmr  <= tick ? '0 : tmr + 1'b1;
      wcnt <= tick ? '0 : (trig ? CW'(LIMIT) : nxt[CW-1:0]);
      if (trig) begin
        hi_ber <= 1'b1;
        hold   <= '0;
      end else begin
        if (tick && hold_done) hi_ber <= 1'b0;
        if (!hold_done) hold <= hold + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || stat_clr)      bad_stat <= '0;
    else if (bad && !stat_max) bad_stat <= bad_stat + 1'b1;
  end

  // R1
  tmr_range_chk: assert property (@(posedge clk) disable iff (rst)
    tmr <= TW'(WIN - 1));

  // R2
  trig_chk: assert property (@(posedge clk) disable iff (rst)
    (lock && hdr_vld && !hdr_ok && wcnt == CW'(LIMIT - 1)) |=> hi_ber);

  // R3
  win_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (lock && tick) |=> (wcnt == '0));

  // R4
  hold_min_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(hi_ber) && !$past(rst)) |-> $past(hold_done && tick));

  // R5
  stat_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (lock && hdr_vld && !hdr_ok && !stat_clr && !stat_max) |=> (bad_stat == $past(bad_stat) + 1'b1));

  // R6
  stat_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_max && !stat_clr) |=> stat_max);

  // R7
  stat_clr_chk: assert property (@(posedge clk) disable iff (rst)
    stat_clr |=> (bad_stat == '0));

  // R8
  unlock_chk: assert property (@(posedge clk) disable iff (rst)
    !lock |=> (hi_ber && wcnt == '0 && tmr == '0));

  // R9
  reset_chk: assert property (@(posedge clk)
    rst |=> (!hi_ber && bad_stat == '0 && wcnt == '0));
endmodule

// File: tb/ber_mon_tb_top.sv
module ber_mon_tb_top;
  localparam int CLK_KHZ = 800;
  localparam int LIMIT   = 16;
  localparam int STAT_W  = 5;
  localparam int WIN     = CLK_KHZ * 125 / 1000;
  localparam int SMAX    = (1 << STAT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1, lock = 1'b1, hdr_vld = 1'b0, hdr_ok = 1'b1, stat_clr = 1'b0;
  logic hi_ber;
  logic [STAT_W-1:0] bad_stat;

  int total = 0, bad = 0;
  bit chk_on = 1'b0, done = 1'b0;

  int m_tmr = 0, m_w = 0, m_h = 0, m_st = 0;
  bit m_hi = 1'b0;

  ber_mon #(.CLK_KHZ(CLK_KHZ), .LIMIT(LIMIT), .STAT_W(STAT_W)) dut_i (
    .clk(clk), .rst(rst), .lock(lock), .hdr_vld(hdr_vld), .hdr_ok(hdr_ok),
    .stat_clr(stat_clr), .hi_ber(hi_ber), .bad_stat(bad_stat));

  always #2.5ns clk = ~clk;

  // Requirement-level model of the expected outputs
  always @(posedge clk) begin
    bit e, tk, tg;
    e = lock && hdr_vld && !hdr_ok;
    if (rst) begin
      m_tmr = 0; m_w = 0; m_h = 0; m_hi = 0; m_st = 0;
    end else if (!lock) begin
      m_tmr = 0; m_w = 0; m_h = 0; m_hi = 1;
      if (stat_clr) m_st = 0;
    end else begin
      tk = (m_tmr == WIN - 1);
      tg = e && (m_w + 1 >= LIMIT);
      if (tg) begin
        m_hi = 1; m_h = 0;
      end else begin
        if (tk && m_h >= WIN) m_hi = 0;
        if (m_h < WIN) m_h++;
      end
      m_w   = tk ? 0 : (tg ? LIMIT : m_w + int'(e));
      m_tmr = tk ? 0 : m_tmr + 1;
      if (stat_clr) m_st = 0;
      else if (e && m_st < SMAX) m_st++;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_on && !done) begin
    check(hi_ber == m_hi, "model hi_ber R2 R4 R8", int'(hi_ber), int'(m_hi));
    check(int'(bad_stat) == m_st, "model bad_stat R5 R6 R7", int'(bad_stat), m_st);
  end

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic step(bit v, bit ok, bit lk, bit clr);
    hdr_vld = v; hdr_ok = ok; lock = lk; stat_clr = clr;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 1, 1, 0);
  endtask

  task automatic align(int ph);
    int g = 0;
    while (m_tmr != ph && g < 1000) begin step(0, 1, 1, 0); g++; end
  endtask

  task automatic errs(int n);
    for (int i = 0; i < n; i++) step(1, 0, 1, 0);
  endtask

  function automatic int hold_steps_ok(int n);
    return (n >= WIN) ? 1 : 0;
  endfunction

  initial begin
    #(5ns * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n, s0;
    @(negedge clk);
    rst = 1'b1;
    idle(3);
    check(hi_ber == 1'b0, "R9 reset hi_ber", int'(hi_ber), 0);
    check(bad_stat == '0, "R9 reset bad_stat", int'(bad_stat), 0);
    rst = 1'b0;
    chk_on = 1'b1;

    // R10: hdr_ok=0 without hdr_vld is ignored
    for (int i = 0; i < 40; i++) step(0, 0, 1, 0);
    check(hi_ber == 1'b0, "R10 hi_ber", int'(hi_ber), 0);
    check(bad_stat == '0, "R10 bad_stat", int'(bad_stat), 0);

    // R2: LIMIT-1 then LIMIT in one window
    align(0);
    errs(LIMIT - 1);
    check(hi_ber == 1'b0, "R2 below limit", int'(hi_ber), 0);
    check(int'(bad_stat) == LIMIT - 1, "R5 count", int'(bad_stat), LIMIT - 1);
    errs(1);
    check(hi_ber == 1'b1, "R2 trigger", int'(hi_ber), 1);
    check(int'(bad_stat) == LIMIT, "R5 count", int'(bad_stat), LIMIT);

    // R4: trigger at phase 15 -> drops at phase 199, 184 steps later
    n = 0;
    while (hi_ber && n < 1000) begin step(0, 1, 1, 0); n++; end
    check(n == 2 * WIN - LIMIT, "R4 hold exact", n, 2 * WIN - LIMIT);
    check(hold_steps_ok(n) == 1, "R4 hold min", n, WIN);

    // R7: clear zeroes counter, leaves flag and window alone
    step(0, 1, 1, 1);
    check(bad_stat == '0, "R7 clear", int'(bad_stat), 0);
    check(hi_ber == 1'b0, "R7 flag kept", int'(hi_ber), 0);

    // R3: burst straddling a boundary
    align(WIN - LIMIT / 2);
    errs(LIMIT);
    check(hi_ber == 1'b0, "R3 straddle", int'(hi_ber), 0);
    check(int'(bad_stat) == LIMIT, "R5 straddle count", int'(bad_stat), LIMIT);

    // R6: saturation
    errs(LIMIT + 4);
    check(int'(bad_stat) == SMAX, "R6 saturate", int'(bad_stat), SMAX);
    check(hi_ber == 1'b1, "R2 retrigger", int'(hi_ber), 1);
    errs(3);
    check(int'(bad_stat) == SMAX, "R6 hold max", int'(bad_stat), SMAX);

    // R7: clear wins over increment, flag untouched
    step(1, 0, 1, 1);
    check(bad_stat == '0, "R7 clear vs inc", int'(bad_stat), 0);
    check(hi_ber == 1'b1, "R7 flag untouched", int'(hi_ber), 1);

    // R8: lock loss
    n = 0;
    while (hi_ber && n < 1000) begin step(0, 1, 1, 0); n++; end
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0);
    check(hi_ber == 1'b1, "R8 forced high", int'(hi_ber), 1);
    check(bad_stat == '0, "R8 headers ignored", int'(bad_stat), 0);
    n = 0;
    while (hi_ber && n < 1000) begin step(0, 1, 1, 0); n++; end
    check(n == 2 * WIN, "R8 relock hold", n, 2 * WIN);

    // R1: window edge at phase WIN-1 / 0
    align(0);
    errs(LIMIT - 1);
    align(0);
    errs(1);
    check(hi_ber == 1'b0, "R1 next window", int'(hi_ber), 0);
    align(0);
    errs(LIMIT - 1);
    align(WIN - 1);
    errs(1);
    check(hi_ber == 1'b1, "R1 last cycle counts", int'(hi_ber), 1);

    // Random phase
    s0 = $urandom(32'h5eed_1234);
    for (int seg = 0; seg < 30; seg++) begin
      int dens = $urandom_range(1, 40);
      for (int i = 0; i < 120; i++) begin
        bit lk = ($urandom_range(0, 299) != 0);
        bit v  = ($urandom_range(0, 3) != 0);
        bit ok = ($urandom_range(0, 99) >= dens);
        bit cl = ($urandom_range(0, 59) == 0);
        step(v, ok, lk, cl);
      end
    end

    // R9: reset during activity
    rst = 1'b1;
    step(1, 0, 1, 0);
    rst = 1'b0;
    check(hi_ber == 1'b0, "R9 late reset hi_ber", int'(hi_ber), 0);
    check(bad_stat == '0, "R9 late reset bad_stat", int'(bad_stat), 0);
    idle(5);
    finish_run();
  end
endmodule